// File: doc/BRIEF.md
# Set-Associative Block Cache Array

This block holds the tag, valid, recency and data storage of a set-associative cache whose lines are blocks of 32-bit words. A lookup port takes a byte address, splits it into word-select, set and tag fields, and compares the tag against every way of the addressed set. One cycle later it reports whether the access hit and, if so, which word was read. A hit also records the current cycle count as that way's recency stamp.

A separate fill port writes a whole block into the set chosen by its address. The way that receives it is an empty way if the set has one. If the set is full, the way whose stamp is oldest is used. The prior contents of that way are reported one cycle later, so the controller around the block can forward a displaced block to the next level: its valid bit, tag, set, data and rebuilt base address. Miss handling, timing of the next level and write policy belong to that controller.

Top module: `sa_cache`

## Requirements
- R1: A byte address splits, starting from bit 0, into a 2-bit byte offset, then log2(words per block) word-select bits, then log2(sets) index bits. All remaining upper bits form the tag. With the default geometry these are byte [1:0], word [2], set [4:3] and tag [31:5]. Word 0 of a block is carried in data bits [31:0].
- R2: Words per block is BLOCK_BYTES/4 and the set count is CACHE_BYTES/(BLOCK_BYTES*WAYS). The defaults of 8, 64 and 2 give 2 words and 4 sets, and each set is independent of the others.
- R3: Reset clears every valid bit and sets all tags and stamps to zero. While reset is held, hit_valid_o and evict_valid_o are low. After reset, lookups miss until a fill occurs.
- R4: hit_valid_o goes high exactly one cycle after lk_valid_i, carrying that lookup's hit_o and rdata_o. rdata_o is zero on a miss.
- R5: A lookup hits only when some way of the addressed set is valid and holds the address tag. rdata_o is then the word picked by the word-select field.
- R6: A lookup with a nonzero byte offset sets misalign_o, never hits, and leaves every recency stamp unchanged.
- R7: A fill places its block in the lowest-numbered invalid way of its set. The word-select and byte bits of the fill address are ignored.
- R8: When every way of the set is valid, a fill replaces the way with the smallest stamp, taking the lowest-numbered way on a tie. Both hits and fills set a way's stamp to the current cycle count.
- R9: evict_valid_o goes high exactly one cycle after fill_valid_i. It carries the replaced way's former valid bit, tag and data, the set index, and the base address {tag, index, zeros}.
- R10: If a lookup and a fill arrive in the same cycle, the lookup sees the set as it was before the fill. The fill chooses its victim without regard to that lookup's hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Lookup byte address |
| fill_valid_i | input | 1 | Fill request |
| fill_addr_i | input | 32 | Fill address (set and tag used) |
| fill_data_i | input | BLOCK_BYTES*8 | Block to write, word 0 in the low bits |
| hit_valid_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Lookup hit |
| misalign_o | output | 1 | Lookup had a nonzero byte offset |
| rdata_o | output | 32 | Word read on a hit, zero otherwise |
| evict_valid_o | output | 1 | Eviction report valid |
| evict_was_valid_o | output | 1 | Replaced way held a valid block |
| evict_tag_o | output | TAG_W | Tag of the replaced block |
| evict_index_o | output | IDX_W | Set of the replaced block |
| evict_addr_o | output | 32 | Base address of the replaced block |
| evict_data_o | output | BLOCK_BYTES*8 | Data of the replaced block |

## Verification
The bench fills both ways of a set, touches them in a chosen order and then forces a replacement. A design that chose the victim by fill order instead of last access would evict the wrong block and report the wrong base address. A misaligned lookup is issued to a resident block before a replacement, so a design that refreshed the stamp on that access would displace the other way. Issuing a lookup in the same cycle as a fill to the same set shows whether the lookup sees pre-fill contents. A refill of a replaced tag, together with a block at the same tag in another set, checks that sets and word selection do not bleed into each other.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 2;
endpackage

// File: rtl/sa_cache_addr.sv
module sa_cache_addr import sa_cache_pkg::*; #(
  parameter int OFF_W = 1,
  parameter int IDX_W = 2,
  parameter int TAG_W = ADDR_W - BYTE_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int OFF_LO = BYTE_W;
  localparam int IDX_LO = OFF_LO + OFF_W;
  localparam int TAG_LO = IDX_LO + IDX_W;

  assign byte_o = addr_i[BYTE_W-1:0];
  assign off_o  = addr_i[OFF_LO +: OFF_W];
  assign idx_o  = addr_i[IDX_LO +: IDX_W];
  assign tag_o  = addr_i[TAG_LO +: TAG_W];
endmodule

// File: rtl/sa_cache_way.sv
module sa_cache_way #(
  parameter int SETS    = 4,
  parameter int IDX_W   = 2,
  parameter int TAG_W   = 27,
  parameter int BLK_W   = 64,
  parameter int STAMP_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   lk_idx_i,
  input  logic               lk_touch_i,
  input  logic [IDX_W-1:0]   fl_idx_i,
  input  logic               fl_we_i,
  input  logic [TAG_W-1:0]   fl_tag_i,
  input  logic [BLK_W-1:0]   fl_data_i,
  input  logic [STAMP_W-1:0] stamp_i,
  output logic               lk_valid_o,
  output logic [TAG_W-1:0]   lk_tag_o,
  output logic [BLK_W-1:0]   lk_data_o,
  output logic               fl_valid_o,
  output logic [TAG_W-1:0]   fl_tag_o,
  output logic [STAMP_W-1:0] fl_stamp_o,
  output logic [BLK_W-1:0]   fl_data_o
);
  logic [SETS-1:0]    valid_q;
  logic [TAG_W-1:0]   tag_q   [SETS];
  logic [STAMP_W-1:0] stamp_q [SETS];
  logic [BLK_W-1:0]   data_q  [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]   <= '0;
        stamp_q[s] <= '0;
        data_q[s]  <= '0;
      end
    end else begin
      if (lk_touch_i) stamp_q[lk_idx_i] <= stamp_i;
      // fill is last so it owns the entry when both target it
      if (fl_we_i) begin
        valid_q[fl_idx_i] <= 1'b1;
        tag_q[fl_idx_i]   <= fl_tag_i;
        stamp_q[fl_idx_i] <= stamp_i;
        data_q[fl_idx_i]  <= fl_data_i;
      end
    end
  end

  assign lk_valid_o = valid_q[lk_idx_i];
  assign lk_tag_o   = tag_q[lk_idx_i];
  assign lk_data_o  = data_q[lk_idx_i];
  assign fl_valid_o = valid_q[fl_idx_i];
  assign fl_tag_o   = tag_q[fl_idx_i];
  assign fl_stamp_o = stamp_q[fl_idx_i];
  assign fl_data_o  = data_q[fl_idx_i];
endmodule

// File: rtl/sa_cache_victim.sv
module sa_cache_victim #(
  parameter int WAYS    = 2,
  parameter int STAMP_W = 32,
  parameter int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]              valid_i,
  input  logic [WAYS-1:0][STAMP_W-1:0] stamp_i,
  output logic [WAY_W-1:0]             way_o
);
  logic               found_inv;
  logic [STAMP_W-1:0] best;

  always_comb begin
    found_inv = 1'b0;
    way_o     = '0;
    best      = stamp_i[0];
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !found_inv) begin
        found_inv = 1'b1;
        way_o     = WAY_W'(w);
      end
    end
    if (!found_inv) begin
      // strict compare keeps the lowest way on a tie
      for (int w = 1; w < WAYS; w++) begin
        if (stamp_i[w] < best) begin
          best  = stamp_i[w];
          way_o = WAY_W'(w);
        end
      end
    end
  end
endmodule

// File: rtl/sa_cache.sv
module sa_cache import sa_cache_pkg::*; #(
  parameter int BLOCK_BYTES = 8,
  parameter int CACHE_BYTES = 64,
  parameter int WAYS        = 2,
  parameter int STAMP_W     = 32,
  localparam int WPB   = BLOCK_BYTES / 4,
  localparam int OFF_W = $clog2(WPB),
  localparam int SETS  = CACHE_BYTES / (BLOCK_BYTES * WAYS),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - BYTE_W - OFF_W - IDX_W,
  localparam int BLK_W = WPB * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [BLK_W-1:0]  fill_data_i,
  output logic              hit_valid_o,
  output logic              hit_o,
  output logic              misalign_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              evict_valid_o,
  output logic              evict_was_valid_o,
  output logic [TAG_W-1:0]  evict_tag_o,
  output logic [IDX_W-1:0]  evict_index_o,
  output logic [ADDR_W-1:0] evict_addr_o,
  output logic [BLK_W-1:0]  evict_data_o
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [BYTE_W-1:0] lk_byte, fl_byte;
  logic [OFF_W-1:0]  lk_off, fl_off;
  logic [IDX_W-1:0]  lk_idx, fl_idx;
  logic [TAG_W-1:0]  lk_tag, fl_tag;

  sa_cache_addr #(.OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lk_split (
    .addr_i(lk_addr_i), .byte_o(lk_byte), .off_o(lk_off), .idx_o(lk_idx), .tag_o(lk_tag)
  );
  sa_cache_addr #(.OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_fl_split (
    .addr_i(fill_addr_i), .byte_o(fl_byte), .off_o(fl_off), .idx_o(fl_idx), .tag_o(fl_tag)
  );

  logic unused_fl;
  assign unused_fl = ^{fl_byte, fl_off};

  logic [STAMP_W-1:0] cyc_q;

  logic [WAYS-1:0]              way_lk_valid, way_fl_valid, hit_vec, touch, fl_we;
  logic [WAYS-1:0][TAG_W-1:0]   way_lk_tag, way_fl_tag;
  logic [WAYS-1:0][BLK_W-1:0]   way_lk_data, way_fl_data;
  logic [WAYS-1:0][STAMP_W-1:0] way_fl_stamp;
  logic [WAY_W-1:0]             vic;
  logic                         aligned, lk_hit;

  assign aligned = (lk_byte == '0);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign hit_vec[g] = way_lk_valid[g] && (way_lk_tag[g] == lk_tag);
    assign touch[g]   = lk_valid_i && aligned && hit_vec[g];
    assign fl_we[g]   = fill_valid_i && (vic == WAY_W'(g));

    sa_cache_way #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W), .STAMP_W(STAMP_W)
    ) u_way (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lk_idx_i   (lk_idx),
      .lk_touch_i (touch[g]),
      .fl_idx_i   (fl_idx),
      .fl_we_i    (fl_we[g]),
      .fl_tag_i   (fl_tag),
      .fl_data_i  (fill_data_i),
      .stamp_i    (cyc_q),
      .lk_valid_o (way_lk_valid[g]),
      .lk_tag_o   (way_lk_tag[g]),
      .lk_data_o  (way_lk_data[g]),
      .fl_valid_o (way_fl_valid[g]),
      .fl_tag_o   (way_fl_tag[g]),
      .fl_stamp_o (way_fl_stamp[g]),
      .fl_data_o  (way_fl_data[g])
    );
  end

  sa_cache_victim #(.WAYS(WAYS), .STAMP_W(STAMP_W), .WAY_W(WAY_W)) u_victim (
    .valid_i(way_fl_valid), .stamp_i(way_fl_stamp), .way_o(vic)
  );

  logic [BLK_W-1:0]  hit_blk;
  logic [WORD_W-1:0] hit_word;

  always_comb begin
    hit_blk = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_blk = hit_blk | way_lk_data[w];
    end
  end

  assign hit_word = hit_blk[lk_off*WORD_W +: WORD_W];
  assign lk_hit   = lk_valid_i && aligned && (|hit_vec);

  logic              hv_q, hit_q, mis_q;
  logic [WORD_W-1:0] rdata_q;
  logic              ev_v_q, ev_was_q;
  logic [TAG_W-1:0]  ev_tag_q;
  logic [IDX_W-1:0]  ev_idx_q;
  logic [BLK_W-1:0]  ev_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q     <= '0;
      hv_q      <= 1'b0;
      hit_q     <= 1'b0;
      mis_q     <= 1'b0;
      rdata_q   <= '0;
      ev_v_q    <= 1'b0;
      ev_was_q  <= 1'b0;
      ev_tag_q  <= '0;
      ev_idx_q  <= '0;
      ev_data_q <= '0;
    end else begin
      cyc_q   <= cyc_q + 1'b1;
      hv_q    <= lk_valid_i;
      hit_q   <= lk_hit;
      mis_q   <= lk_valid_i && !aligned;
      rdata_q <= lk_hit ? hit_word : '0;
      ev_v_q  <= fill_valid_i;
      if (fill_valid_i) begin
        ev_was_q  <= way_fl_valid[vic];
        ev_tag_q  <= way_fl_tag[vic];
        ev_idx_q  <= fl_idx;
        ev_data_q <= way_fl_data[vic];
      end
    end
  end

  assign hit_valid_o       = hv_q;
  assign hit_o             = hit_q;
  assign misalign_o        = mis_q;
  assign rdata_o           = rdata_q;
  assign evict_valid_o     = ev_v_q;
  assign evict_was_valid_o = ev_was_q;
  assign evict_tag_o       = ev_tag_q;
  assign evict_index_o     = ev_idx_q;
  assign evict_addr_o      = {ev_tag_q, ev_idx_q, {(OFF_W + BYTE_W){1'b0}}};
  assign evict_data_o      = ev_data_q;

  AST_LOOKUP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> hit_valid_o); // R4
  AST_NO_STRAY_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !hit_valid_o); // R4
  AST_HIT_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> hit_valid_o); // R5
  AST_MISALIGN_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !hit_o); // R6
  AST_INVALID_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !(&way_fl_valid)) |-> !way_fl_valid[vic]); // R7
  AST_EVICT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |=> evict_valid_o); // R9

  for (genvar g = 0; g < WAYS; g++) begin : g_lru_chk
    AST_VICTIM_OLDEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fill_valid_i && (&way_fl_valid)) |-> (way_fl_stamp[vic] <= way_fl_stamp[g])); // R8
  end
endmodule

// File: tb/sa_cache_tb.sv
module sa_cache_tb;
  localparam time TCLK = 20ns;

  typedef struct packed {
    logic        is_fill;
    logic [31:0] addr;
    logic [63:0] data;
    logic        exp_flag;  // hit for lookup, was_valid for fill
    logic [31:0] exp_word;  // rdata, or evicted word 0
    logic [31:0] exp_addr;  // evicted base address
  } vec_t;

  // default geometry: tag [31:5], set [4:3], word [2], byte [1:0]
  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 32'h208, 64'h000000A1_000000A0, 1'b0, 32'h0,  32'h0},   // R7 A -> way0
    '{1'b1, 32'h408, 64'h000000B1_000000B0, 1'b0, 32'h0,  32'h0},   // R7 B -> way1
    '{1'b0, 32'h20C, 64'h0,                 1'b1, 32'hA1, 32'h0},   // R5 R1 word1
    '{1'b0, 32'h408, 64'h0,                 1'b1, 32'hB0, 32'h0},   // R5 word0
    '{1'b0, 32'h608, 64'h0,                 1'b0, 32'h0,  32'h0},   // R5 miss
    '{1'b1, 32'h608, 64'h000000C1_000000C0, 1'b1, 32'hA0, 32'h208}, // R8 evict A
    '{1'b0, 32'h208, 64'h0,                 1'b0, 32'h0,  32'h0},   // R5 A gone
    '{1'b0, 32'h60C, 64'h0,                 1'b1, 32'hC1, 32'h0},   // R5
    '{1'b0, 32'h40C, 64'h0,                 1'b1, 32'hB1, 32'h0},   // R8 touch B
    '{1'b1, 32'h208, 64'h000000A1_000000A0, 1'b1, 32'hC0, 32'h608}, // R8 evict C
    '{1'b1, 32'h214, 64'h000000D1_000000D0, 1'b0, 32'h0,  32'h0},   // R2 R7 set2, offset ignored
    '{1'b0, 32'h214, 64'h0,                 1'b1, 32'hD1, 32'h0},   // R2 same tag other set
    '{1'b0, 32'h208, 64'h0,                 1'b1, 32'hA0, 32'h0}    // R2 set1 intact
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        fl_valid = 1'b0;
  logic [31:0] fl_addr = '0;
  logic [63:0] fl_data = '0;

  logic        hit_valid, hit, misalign, ev_valid, ev_was;
  logic [31:0] rdata, ev_addr;
  logic [26:0] ev_tag;
  logic [1:0]  ev_idx;
  logic [63:0] ev_data;

  int checks = 0;
  int errors = 0;

  always #(TCLK/2) clk = ~clk;

  sa_cache u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid), .lk_addr_i(lk_addr),
    .fill_valid_i(fl_valid), .fill_addr_i(fl_addr), .fill_data_i(fl_data),
    .hit_valid_o(hit_valid), .hit_o(hit), .misalign_o(misalign), .rdata_o(rdata),
    .evict_valid_o(ev_valid), .evict_was_valid_o(ev_was), .evict_tag_o(ev_tag),
    .evict_index_o(ev_idx), .evict_addr_o(ev_addr), .evict_data_o(ev_data)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, return at the next falling edge
  task automatic step(input logic lv, input logic [31:0] la,
                      input logic fv, input logic [31:0] fa, input logic [63:0] fd);
    lk_valid = lv; lk_addr = la; fl_valid = fv; fl_addr = fa; fl_data = fd;
    @(negedge clk);
    lk_valid = 1'b0; fl_valid = 1'b0;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(TCLK * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 reset hit_valid", {63'b0, hit_valid}, 64'd0);
    chk("R3 reset evict_valid", {63'b0, ev_valid}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    step(1'b1, 32'h208, 1'b0, 32'h0, 64'h0);
    chk("R3 empty after reset", {63'b0, hit}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].is_fill) begin
        step(1'b0, 32'h0, 1'b1, TBL[i].addr, TBL[i].data);
        chk("R9 evict_valid", {63'b0, ev_valid}, 64'd1);
        chk("R7 R8 was_valid", {63'b0, ev_was}, {63'b0, TBL[i].exp_flag});
        if (TBL[i].exp_flag) begin
          chk("R8 R9 evict word0", {32'b0, ev_data[31:0]}, {32'b0, TBL[i].exp_word});
          chk("R9 evict base addr", {32'b0, ev_addr}, {32'b0, TBL[i].exp_addr});
          chk("R9 evict tag", {37'b0, ev_tag}, {37'b0, TBL[i].exp_addr[31:5]});
        end
      end else begin
        step(1'b1, TBL[i].addr, 1'b0, 32'h0, 64'h0);
        chk("R4 hit_valid", {63'b0, hit_valid}, 64'd1);
        chk("R5 hit", {63'b0, hit}, {63'b0, TBL[i].exp_flag});
        chk("R4 R5 rdata", {32'b0, rdata}, {32'b0, TBL[i].exp_word});
      end
    end
    step(1'b0, 32'h0, 1'b0, 32'h0, 64'h0);
    chk("R4 idle", {63'b0, hit_valid}, 64'd0);

    // R6: misaligned access to E must not refresh its stamp (set 0)
    step(1'b0, 32'h0, 1'b1, 32'hA00, 64'h000000E1_000000E0);
    step(1'b0, 32'h0, 1'b1, 32'hA20, 64'h000000F1_000000F0);
    step(1'b1, 32'hA01, 1'b0, 32'h0, 64'h0);
    chk("R6 misalign flag", {63'b0, misalign}, 64'd1);
    chk("R6 no hit", {63'b0, hit}, 64'd0);
    step(1'b0, 32'h0, 1'b1, 32'hA40, 64'h0000_0011_0000_0010);
    chk("R6 stamp untouched", {32'b0, ev_addr}, 64'hA00);
    chk("R9 evict index", {62'b0, ev_idx}, 64'd0);

    // R10: same-cycle lookup and fill on set 3
    step(1'b0, 32'h0, 1'b1, 32'h838, 64'h00000071_00000070);
    step(1'b0, 32'h0, 1'b1, 32'h858, 64'h00000081_00000080);
    step(1'b1, 32'h838, 1'b0, 32'h0, 64'h0);
    chk("R8 touch X", {63'b0, hit}, 64'd1);
    step(1'b1, 32'h858, 1'b1, 32'h878, 64'h00000091_00000090);
    chk("R10 lookup sees pre-fill", {63'b0, hit}, 64'd1);
    chk("R10 pre-fill data", {32'b0, rdata}, 64'h80);
    chk("R10 victim Y", {32'b0, ev_addr}, 64'h858);
    step(1'b1, 32'h858, 1'b0, 32'h0, 64'h0);
    chk("R10 Y replaced", {63'b0, hit}, 64'd0);
    step(1'b1, 32'h87C, 1'b0, 32'h0, 64'h0);
    chk("R10 Z resident", {32'b0, rdata}, 64'h91);

    // R3: reset mid-run clears contents
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R3 hit_valid in reset", {63'b0, hit_valid}, 64'd0);
    chk("R3 evict_valid in reset", {63'b0, ev_valid}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    step(1'b1, 32'h87C, 1'b0, 32'h0, 64'h0);
    chk("R3 cleared after reset", {63'b0, hit}, 64'd0);

    report();
  end
endmodule